// File: doc/BRIEF.md
# DDR3 Bank Timing Tracker

This block sits beside a DDR3 memory controller and watches the commands it issues to an eight-bank device. For every bank it keeps the time since the last row activation and the last precharge, and from these it drives three ready vectors. Each vector has one bit per bank and says whether an ACTIVATE, a column access (READ or WRITE) or a PRECHARGE to that bank would meet the device's minimum intervals on the current cycle. The scheduler reads these bits before it picks a command.

The minimum intervals are whole clock counts chosen by a speed-bin select. Each bin's nanosecond limits are turned into clocks by rounding up against that bin's clock period. If a command arrives anyway for a bank that is not ready, the tracker applies it as issued and raises a one-cycle violation pulse tagged with the bank and the command. A separate countdown raises a refresh-due flag once per average refresh interval. The interval is halved while the high-temperature input is set, and a REFRESH command clears the flag.

Top module: `ddr_bank_timer`

## Requirements
- R1: After synchronous reset all banks are closed, `actReady` and `preReady` are all ones, `rwReady` is all zeros, `refDue` is 0, `vioValid` is 0, and the refresh countdown holds the full cool interval.
- R2: `cmdIn` is decoded as 0 = idle, 1 = ACTIVATE, 2 = READ, 3 = WRITE, 4 = PRECHARGE, 5 = REFRESH. Codes 6 and 7 act as idle. `bankIn` selects the bank for ACTIVATE, READ, WRITE and PRECHARGE.
- R3: `rwReady[b]` is 1 only when bank b is open and at least tRCD clocks have passed since its ACTIVATE. A command issued n edges after the ACTIVATE counts n clocks.
- R4: `preReady[b]` is 1 when bank b is closed, or when it is open and at least tRAS clocks have passed since its ACTIVATE. A PRECHARGE to a closed bank changes nothing.
- R5: `actReady[b]` is 1 only when bank b is closed, at least tRP clocks have passed since the PRECHARGE that closed it, and at least tRC clocks have passed since its previous ACTIVATE.
- R6: `binSel` values 0 to 5 give (tRCD = tRP, tRAS, tRC) in clocks of (6,15,21), (7,20,27), (9,24,33), (11,28,39), (13,32,45) and (14,36,50). Values 6 and 7 give (14,36,50).
- R7: A command whose ready bit is 0 on the cycle it is issued makes `vioValid` high for exactly the next cycle, with `vioBank` and `vioCmd` equal to the offending bank and code. The command still updates the bank state. Idle and REFRESH never cause a violation.
- R8: Each bank's state changes only on commands addressed to it. Commands to one bank leave every other bank's ready bits unaffected.
- R9: `refDue` is set on the REFI_CLKS-th rising edge after the countdown was loaded, and the countdown then reloads. While `hotIn` is 1 the interval is REFI_CLKS/2.
- R10: REFRESH clears `refDue` on the next edge. If the countdown expires on the same edge, the flag stays set.
- R11: A change of `hotIn` reloads the countdown with the interval of the new range on the next edge. No expiry happens on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmdIn | input | 3 | Decoded command code (R2) |
| bankIn | input | 3 | Bank addressed by the command |
| binSel | input | 3 | Speed-bin select |
| hotIn | input | 1 | High-temperature range flag |
| actReady | output | 8 | Per-bank ACTIVATE legal |
| rwReady | output | 8 | Per-bank READ/WRITE legal |
| preReady | output | 8 | Per-bank PRECHARGE legal |
| refDue | output | 1 | Refresh interval expired |
| vioValid | output | 1 | One-cycle protocol-violation pulse |
| vioBank | output | 3 | Bank of the violating command |
| vioCmd | output | 3 | Code of the violating command |

## Verification
The bench issues column reads on every cycle just after an ACTIVATE. This exposes an off-by-one in the tRCD count, which would move the first legal read one cycle early or late and shift the violation pulses with it. It precharges before tRAS and re-activates at once to show that an illegal command still changes state. A tracker that dropped illegal commands would keep the bank open and report the wrong ready bits from then on. It switches bins mid-run, including the fallback codes, where a mistake in the round-up rule shows up as a one-clock error in tRAS or tRC. It also sends REFRESH on the exact edge the countdown expires and toggles the temperature range mid-count. A design that let the clear win, or that kept counting from the old interval, would place the next due flag at the wrong cycle.

// File: rtl/ddrTimPkg.sv
package ddrTimPkg;
  localparam int BANKS  = 8;
  localparam int BANK_W = $clog2(BANKS);
  localparam int CNT_W  = 6;
  localparam int CMD_W  = 3;
  localparam int SEL_W  = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5
  } cmd_e;

  typedef struct packed {
    logic [CNT_W-1:0] rcd;
    logic [CNT_W-1:0] rp;
    logic [CNT_W-1:0] ras;
    logic [CNT_W-1:0] rc;
  } limits_t;

  typedef struct packed {
    logic              actStb;
    logic              preStb;
    logic              refStb;
    logic [BANK_W-1:0] bank;
  } strobe_t;

  // Clock counts per bin: ns limits rounded up against the bin's period.
  function automatic limits_t binLimits(input logic [SEL_W-1:0] sel);
    limits_t l;
    case (sel)
      3'd0:    l = '{rcd: 6'd6,  rp: 6'd6,  ras: 6'd15, rc: 6'd21};
      3'd1:    l = '{rcd: 6'd7,  rp: 6'd7,  ras: 6'd20, rc: 6'd27};
      3'd2:    l = '{rcd: 6'd9,  rp: 6'd9,  ras: 6'd24, rc: 6'd33};
      3'd3:    l = '{rcd: 6'd11, rp: 6'd11, ras: 6'd28, rc: 6'd39};
      3'd4:    l = '{rcd: 6'd13, rp: 6'd13, ras: 6'd32, rc: 6'd45};
      default: l = '{rcd: 6'd14, rp: 6'd14, ras: 6'd36, rc: 6'd50};
    endcase
    return l;
  endfunction
endpackage

// File: rtl/ddrTimControl.sv
module ddrTimControl
  import ddrTimPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CMD_W-1:0]  cmdIn,
  input  logic [BANK_W-1:0] bankIn,
  input  logic [BANKS-1:0]  actReady,
  input  logic [BANKS-1:0]  rwReady,
  input  logic [BANKS-1:0]  preReady,
  output strobe_t           stb,
  output logic              vioValid,
  output logic [BANK_W-1:0] vioBank,
  output logic [CMD_W-1:0]  vioCmd
);
  logic illegal;

  always_comb begin
    stb      = '0;
    stb.bank = bankIn;
    illegal  = 1'b0;
    case (cmdIn)
      CMD_ACT: begin
        stb.actStb = 1'b1;
        illegal    = !actReady[bankIn];
      end
      CMD_RD, CMD_WR: illegal = !rwReady[bankIn];
      CMD_PRE: begin
        stb.preStb = 1'b1;
        illegal    = !preReady[bankIn];
      end
      CMD_REF: stb.refStb = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vioValid <= 1'b0;
      vioBank  <= '0;
      vioCmd   <= '0;
    end else begin
      vioValid <= illegal;
      if (illegal) begin
        vioBank <= bankIn;
        vioCmd  <= cmdIn;
      end
    end
  end

  assert_act_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (cmdIn == CMD_ACT && !actReady[bankIn]) |=> (vioValid && vioBank == $past(bankIn)));

  assert_rw_flag_R7: assert property (@(posedge clk) disable iff (rst)
    ((cmdIn == CMD_RD || cmdIn == CMD_WR) && !rwReady[bankIn]) |=> (vioValid && vioCmd == $past(cmdIn)));

  assert_quiet_cmds_R7: assert property (@(posedge clk) disable iff (rst)
    (cmdIn == CMD_NOP || cmdIn == CMD_REF || cmdIn > CMD_REF) |=> !vioValid);
endmodule

// File: rtl/ddrTimDatapath.sv
module ddrTimDatapath
  import ddrTimPkg::*;
#(
  parameter int REFI_CLKS = 6240
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          stb,
  input  logic [SEL_W-1:0] binSel,
  input  logic             hotIn,
  output logic [BANKS-1:0] actReady,
  output logic [BANKS-1:0] rwReady,
  output logic [BANKS-1:0] preReady,
  output logic             refDue
);
  localparam int REF_W = $clog2(REFI_CLKS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [REF_W-1:0] LOAD_COOL = REF_W'(REFI_CLKS - 1);
  localparam logic [REF_W-1:0] LOAD_HOT  = REF_W'(REFI_CLKS / 2 - 1);

  limits_t lim;
  always_comb lim = binLimits(binSel);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [CNT_W-1:0] sinceAct;
    logic [CNT_W-1:0] sincePre;
    logic             isOpen;
    logic             hit;

    assign hit = (stb.bank == BANK_W'(b));

    always_ff @(posedge clk) begin
      if (rst) begin
        sinceAct <= CNT_MAX;
        sincePre <= CNT_MAX;
        isOpen   <= 1'b0;
      end else begin
        if (stb.actStb && hit) begin
          sinceAct <= CNT_W'(1);
          isOpen   <= 1'b1;
        end else if (sinceAct != CNT_MAX) begin
          sinceAct <= sinceAct + CNT_W'(1);
        end
        if (stb.preStb && hit && isOpen) begin
          sincePre <= CNT_W'(1);
          isOpen   <= 1'b0;
        end else if (sincePre != CNT_MAX) begin
          sincePre <= sincePre + CNT_W'(1);
        end
      end
    end

    assign actReady[b] = !isOpen && (sincePre >= lim.rp) && (sinceAct >= lim.rc);
    assign rwReady[b]  = isOpen && (sinceAct >= lim.rcd);
    assign preReady[b] = !isOpen || (sinceAct >= lim.ras);
  end

  logic [REF_W-1:0] refCnt;
  logic [REF_W-1:0] refLoad;
  logic             hotQ;
  logic             rangeChg;

  assign refLoad  = hotIn ? LOAD_HOT : LOAD_COOL;
  assign rangeChg = (hotIn != hotQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      refCnt <= LOAD_COOL;
      hotQ   <= 1'b0;
      refDue <= 1'b0;
    end else begin
      hotQ <= hotIn;
      if (rangeChg || refCnt == '0) refCnt <= refLoad;
      else                          refCnt <= refCnt - REF_W'(1);
      if (!rangeChg && refCnt == '0) refDue <= 1'b1;
      else if (stb.refStb)           refDue <= 1'b0;
    end
  end

  assert_act_blocks_reuse_R5: assert property (@(posedge clk) disable iff (rst)
    stb.actStb |=> !actReady[$past(stb.bank)]);

  assert_act_blocks_pre_R4: assert property (@(posedge clk) disable iff (rst)
    stb.actStb |=> !preReady[$past(stb.bank)]);

  assert_due_from_expiry_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(refDue) |-> ($past(refCnt) == '0));

  assert_due_holds_R10: assert property (@(posedge clk) disable iff (rst)
    (refDue && !stb.refStb) |=> refDue);

  assert_range_reload_R11: assert property (@(posedge clk) disable iff (rst)
    rangeChg |=> (refCnt == (hotQ ? LOAD_HOT : LOAD_COOL)));
endmodule

// File: rtl/ddr_bank_timer.sv
module ddr_bank_timer
  import ddrTimPkg::*;
#(
  parameter int REFI_CLKS = 6240
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       cmdIn,
  input  logic [2:0]       bankIn,
  input  logic [2:0]       binSel,
  input  logic             hotIn,
  output logic [7:0]       actReady,
  output logic [7:0]       rwReady,
  output logic [7:0]       preReady,
  output logic             refDue,
  output logic             vioValid,
  output logic [2:0]       vioBank,
  output logic [2:0]       vioCmd
);
  strobe_t stb;

  ddrTimControl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cmdIn    (cmdIn),
    .bankIn   (bankIn),
    .actReady (actReady),
    .rwReady  (rwReady),
    .preReady (preReady),
    .stb      (stb),
    .vioValid (vioValid),
    .vioBank  (vioBank),
    .vioCmd   (vioCmd)
  );

  ddrTimDatapath #(.REFI_CLKS(REFI_CLKS)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .binSel   (binSel),
    .hotIn    (hotIn),
    .actReady (actReady),
    .rwReady  (rwReady),
    .preReady (preReady),
    .refDue   (refDue)
  );
endmodule

// File: tb/ddr_bank_timer_tb.sv
`timescale 1ns/1ps
module ddr_bank_timer_tb;
  localparam int REFI = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] cmdIn = '0, bankIn = '0, binSel = '0;
  logic hotIn = 1'b0;
  logic [7:0] actReady, rwReady, preReady;
  logic refDue, vioValid;
  logic [2:0] vioBank, vioCmd;

  int nChk = 0, nFail = 0;
  string tag = "R1";

  int mAct[8], mPre[8];
  bit mOpen[8];
  int mRefLeft;
  bit mDue, mPrevHot;

  always #2 clk = ~clk;

  ddr_bank_timer #(.REFI_CLKS(REFI)) u_dut (
    .clk(clk), .rst(rst), .cmdIn(cmdIn), .bankIn(bankIn), .binSel(binSel),
    .hotIn(hotIn), .actReady(actReady), .rwReady(rwReady), .preReady(preReady),
    .refDue(refDue), .vioValid(vioValid), .vioBank(vioBank), .vioCmd(vioCmd)
  );

  function automatic int ceilDiv(int a, int b);
    return (a + b - 1) / b;
  endfunction

  // Limits from the bin tables: clocks for rcd/rp, ps limits rounded up by tCK.
  function automatic int limRcd(int s);
    int cl[6] = '{6, 7, 9, 11, 13, 14};
    return (s > 5) ? 14 : cl[s];
  endfunction
  function automatic int limRas(int s);
    int tck[6] = '{2500, 1875, 1500, 1250, 1070, 935};
    int ras[6] = '{37500, 37500, 36000, 35000, 34000, 33000};
    return (s > 5) ? 36 : ceilDiv(ras[s], tck[s]);
  endfunction
  function automatic int limRc(int s);
    int tck[6] = '{2500, 1875, 1500, 1250, 1070, 935};
    int rc[6]  = '{52500, 50625, 49500, 48750, 47910, 46090};
    return (s > 5) ? 50 : ceilDiv(rc[s], tck[s]);
  endfunction

  function automatic bit actOk(int b);
    return !mOpen[b] && mPre[b] >= limRcd(binSel) && mAct[b] >= limRc(binSel);
  endfunction
  function automatic bit rwOk(int b);
    return mOpen[b] && mAct[b] >= limRcd(binSel);
  endfunction
  function automatic bit preOk(int b);
    return !mOpen[b] || mAct[b] >= limRas(binSel);
  endfunction

  task automatic chk(bit ok, string what, int act, int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    logic [7:0] eA, eW, eP;
    for (int b = 0; b < 8; b++) begin
      eA[b] = actOk(b);
      eW[b] = rwOk(b);
      eP[b] = preOk(b);
    end
    chk(actReady == eA, "R5 actReady", actReady, eA);
    chk(rwReady == eW, "R3 rwReady", rwReady, eW);
    chk(preReady == eP, "R4 preReady", preReady, eP);
    chk(refDue == mDue, "R9 refDue", refDue, mDue);
  endtask

  task automatic step(int c, int b);
    bit eVio;
    cmdIn  = 3'(c);
    bankIn = 3'(b);
    case (c)
      1:       eVio = !actOk(b);
      2, 3:    eVio = !rwOk(b);
      4:       eVio = !preOk(b);
      default: eVio = 1'b0;
    endcase
    @(posedge clk);
    #1;
    for (int i = 0; i < 8; i++) begin
      if (mAct[i] < 1000) mAct[i]++;
      if (mPre[i] < 1000) mPre[i]++;
    end
    if (c == 1) begin
      mAct[b] = 1;
      mOpen[b] = 1'b1;
    end else if (c == 4 && mOpen[b]) begin
      mPre[b] = 1;
      mOpen[b] = 1'b0;
    end
    if (hotIn != mPrevHot) begin
      mPrevHot = hotIn;
      mRefLeft = hotIn ? REFI / 2 : REFI;
      if (c == 5) mDue = 1'b0;
    end else begin
      mRefLeft--;
      if (mRefLeft == 0) begin
        mDue = 1'b1;
        mRefLeft = hotIn ? REFI / 2 : REFI;
      end else if (c == 5) begin
        mDue = 1'b0;
      end
    end
    compareAll();
    chk(vioValid == eVio, "R7 vioValid", vioValid, eVio);
    if (eVio && vioValid) begin
      chk(vioBank == 3'(b), "R7 vioBank", vioBank, b);
      chk(vioCmd == 3'(c), "R7 vioCmd", vioCmd, c);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", nChk - nFail, nChk);
  endtask

  initial begin
    #(200000 * 4);
    nChk++;
    nFail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    for (int i = 0; i < 8; i++) begin
      mAct[i] = 1000;
      mPre[i] = 1000;
      mOpen[i] = 1'b0;
    end
    mRefLeft = REFI;
    mDue = 1'b0;
    mPrevHot = 1'b0;
    // R1: reset state
    tag = "R1";
    chk(actReady == 8'hFF, "R1 actReady", actReady, 255);
    chk(rwReady == 8'h00, "R1 rwReady", rwReady, 0);
    chk(preReady == 8'hFF, "R1 preReady", preReady, 255);
    chk(refDue == 1'b0, "R1 refDue", refDue, 0);
    chk(vioValid == 1'b0, "R1 vioValid", vioValid, 0);

    // R3: reads every cycle after ACTIVATE, first five illegal at bin 0
    tag = "R3";
    step(1, 0);
    for (int i = 0; i < 7; i++) step(2, 0);
    // R4/R7: early precharge then immediate re-activate; state still applied
    tag = "R4";
    step(4, 0);
    step(1, 0);
    tag = "R5";
    idle(25);
    step(1, 0);
    step(3, 0);
    // R8: interleaved banks, precharge to idle bank 5 must change nothing
    tag = "R8";
    step(1, 1);
    step(1, 2);
    step(4, 5);
    step(1, 5);
    for (int i = 0; i < 6; i++) begin
      step(2, 1);
      step(3, 2);
    end
    for (int i = 0; i < 14; i++) step(4, 1 + (i % 2));
    idle(10);
    // R6: other bins and fallback codes
    for (int s = 1; s < 8; s++) begin
      tag = "R6";
      binSel = 3'(s);
      step(1, 3);
      for (int i = 0; i < 15; i++) step(2, 3);
      for (int i = 0; i < 25; i++) step(4, 3);
      for (int i = 0; i < 20; i++) step(1, 3);
      step(4, 3);
      idle(16);
    end
    binSel = 3'd0;
    // R2: codes 6 and 7 behave as idle
    tag = "R2";
    step(1, 4);
    step(6, 4);
    step(7, 4);
    step(2, 4);
    // R9/R10: expiry, clear, clear on the expiry edge
    tag = "R9";
    while (!mDue) step(0, 0);
    idle(3);
    tag = "R10";
    step(5, 0);
    while (mRefLeft != 1) step(0, 0);
    step(5, 0);
    step(5, 0);
    // R11: range change mid-count, hot interval halves
    tag = "R11";
    idle(30);
    hotIn = 1'b1;
    step(0, 0);
    while (!mDue) step(0, 0);
    step(5, 0);
    idle(20);
    hotIn = 1'b0;
    idle(REFI + 5);
    step(5, 0);
    summary();
    $finish;
  end
endmodule